// File: doc/BRIEF.md
# CompactFlash True IDE PIO Cycle Engine

This block connects a simple request/acknowledge host port to a CompactFlash card wired for True IDE operation. Each host request becomes exactly one programmed-I/O bus cycle on the card: a chip select, a read or write strobe, a three-bit register address and a sixteen-bit data bus with per-byte-lane output enables. Setup, strobe pulse and total cycle lengths are held in timing registers counted in clock periods. When the IORDY input is enabled, the card can stretch the strobe.

The task-file registers and the data register share one card address, so the host picks the transfer width on every request. A byte request reaches a task-file register and a sixteen-bit request reaches the data register. The top three host address bits choose between the task-file window and the alternate window, which holds alternate status and device control. A read may be followed by a bus-release gap whose length depends on the PIO mode. The IORDY enable is derived from the PIO mode and two device properties, using the same rule that software applies when it programs the card.

Top module: `cfide_pio_engine`

## Requirements
- R1: After reset the bus is idle: both chip selects, both strobes and the lane enables are inactive, and ack and done are low. The timing registers hold PIO mode 0 values rounded up to whole clocks (600 ns cycle, 70 ns setup, 290 ns pulse), with IORDY waiting off and a 30 ns float gap.
- R2: Address bits [23:21] = 3'b110 with bits [20:3] zero select chip select 0 (task file). Bits [23:21] = 3'b111 with bits [20:3] zero select chip select 1 (alternate status/control). Any other address produces no bus cycle and returns done with err=1 and rdata=0.
- R3: Chip select goes low on the first bus clock with no setup time. It stays low for exactly the cycle count on reads and on writes, plus any IORDY stretch.
- R4: A read pulses only the read strobe and a write pulses only the write strobe. The strobe goes low after the setup count and stays low for the pulse count. The two strobes are never low together.
- R5: With wide=1 the access is 16-bit: lane enables are 2'b11 on writes and rdata returns all 16 card bits. With wide=0 only lane 0 is driven (2'b01), dout[15:8] is 0 and rdata[15:8] is 0. Bits [7:0] always carry the low byte.
- R6: A request is accepted only while idle. Ack is a one-clock pulse on the first bus clock of the accepted access. Done is a one-clock pulse on the clock after the bus cycle, with rdata valid. Each accepted request produces exactly one done.
- R7: After a read, the next chip select cannot go low until float+1 clocks after chip select releases. After a write, the gap is one clock.
- R8: With IORDY waiting enabled, if IORDY is sampled low on the last pulse clock, the strobe stays low until IORDY is sampled high. The rest of the cycle then follows, so the chip-select length grows by the same number of clocks.
- R9: IORDY waiting is on when the PIO mode is above 2 or the device reports IORDY support. It is off when the device is a CompactFlash card in a PIO mode above 4.
- R10: The float count is ceil(30 ns x f_clk) for PIO modes 0 to 4 and ceil(20 ns x f_clk) for mode 5.
- R11: Timing registers are sampled when a request is accepted. A configuration write during a bus cycle affects only later accesses.
- R12: The card address equals host address bits [2:0] throughout the bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req_i | input | 1 | Request, held until ack |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_wide_i | input | 1 | 1 = 16-bit data register, 0 = byte task-file access |
| host_addr_i | input | ADDR_W | Host address; top bits select the window |
| host_wdata_i | input | 16 | Write data |
| host_ack_o | output | 1 | Request accepted (one clock) |
| host_done_o | output | 1 | Access finished (one clock) |
| host_err_o | output | 1 | Undecoded address, valid with done |
| host_rdata_o | output | 16 | Read data, valid with done |
| cfg_wr_i | input | 1 | Load timing registers |
| cfg_setup_i | input | CNT_W | Strobe setup clocks |
| cfg_pulse_i | input | CNT_W | Strobe pulse clocks |
| cfg_cycle_i | input | CNT_W | Total cycle clocks |
| cfg_pio_i | input | 3 | PIO mode 0..5 |
| cfg_dev_iordy_i | input | 1 | Device reports IORDY support |
| cfg_is_cfa_i | input | 1 | Device is a CompactFlash card |
| ide_cs0_n_o | output | 1 | Task-file chip select, active low |
| ide_cs1_n_o | output | 1 | Alternate-window chip select, active low |
| ide_rd_n_o | output | 1 | Read strobe, active low |
| ide_wr_n_o | output | 1 | Write strobe, active low |
| ide_addr_o | output | 3 | Card register address |
| ide_dout_o | output | 16 | Card write data |
| ide_doe_o | output | 2 | Byte-lane output enables |
| ide_din_i | input | 16 | Card read data |
| ide_iordy_i | input | 1 | Card ready; low stretches the strobe |

## Verification
The assertions assume that every accepted, decoded request sees legal timing: a pulse count of at least one, and a cycle count no smaller than setup plus pulse. The bench programs only such combinations and includes the tight case where the cycle equals setup plus pulse. The assertions also assume that the card drives IORDY synchronously and returns it high within a bounded time. The bench card model holds IORDY low for a chosen number of strobe clocks and then raises it. It keeps each timing write and each IORDY window aligned to accesses it waits for, and it chains back-to-back requests only where no IORDY stretch applies.

// File: rtl/cfide_pkg.sv
`timescale 1ns/1ps
// Shared types and timing helpers for the True IDE cycle engine.
// Assumes clock rates of a few GHz at most, so products fit in 64 bits.
package cfide_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_FLOAT} seq_state_e;
    typedef enum logic [1:0] {WIN_NONE, WIN_TASK, WIN_ALT} win_e;

    // Converts nanoseconds to whole clocks, rounding up.
    function automatic int unsigned ns_to_clk(int unsigned ns, longint unsigned hz);
        longint unsigned prod;
        prod = longint'(ns) * hz + 64'd999_999_999;
        return 32'(prod / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/cfide_timing_regs.sv
`timescale 1ns/1ps
// Timing register bank plus PIO-mode policy (IORDY enable, float gap).
// Assumes the host writes legal setup/pulse/cycle triples.
module cfide_timing_regs
    import cfide_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 100_000_000,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] setup_i,
    input  logic [CNT_W-1:0] pulse_i,
    input  logic [CNT_W-1:0] cycle_i,
    input  logic [2:0]       pio_i,
    input  logic             dev_iordy_i,
    input  logic             is_cfa_i,
    output logic [CNT_W-1:0] setup_o,
    output logic [CNT_W-1:0] pulse_o,
    output logic [CNT_W-1:0] cycle_o,
    output logic [CNT_W-1:0] float_o,
    output logic             iordy_en_o
);

    localparam logic [CNT_W-1:0] RST_CYCLE = CNT_W'(ns_to_clk(600, CLK_HZ));
    localparam logic [CNT_W-1:0] RST_SETUP = CNT_W'(ns_to_clk(70, CLK_HZ));
    localparam logic [CNT_W-1:0] RST_PULSE = CNT_W'(ns_to_clk(290, CLK_HZ));
    localparam logic [CNT_W-1:0] FLOAT_SLOW = CNT_W'(ns_to_clk(30, CLK_HZ));
    localparam logic [CNT_W-1:0] FLOAT_FAST = CNT_W'(ns_to_clk(20, CLK_HZ));

    logic [CNT_W-1:0] setup_q, pulse_q, cycle_q;
    logic [2:0]       pio_q;
    logic             dev_q, cfa_q;

    // Holds the programmed timing; resets to PIO mode 0 with IORDY off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= RST_SETUP;
            pulse_q <= RST_PULSE;
            cycle_q <= RST_CYCLE;
            pio_q   <= 3'd0;
            dev_q   <= 1'b0;
            cfa_q   <= 1'b0;
        end else if (wr_i) begin
            setup_q <= setup_i;
            pulse_q <= pulse_i;
            cycle_q <= cycle_i;
            pio_q   <= pio_i;
            dev_q   <= dev_iordy_i;
            cfa_q   <= is_cfa_i;
        end
    end

    // Derives IORDY enable and float length from the stored mode.
    always_comb begin
        iordy_en_o = ((pio_q > 3'd2) || dev_q) && !(cfa_q && (pio_q > 3'd4));
        float_o    = (pio_q >= 3'd5) ? FLOAT_FAST : FLOAT_SLOW;
    end

    assign setup_o = setup_q;
    assign pulse_o = pulse_q;
    assign cycle_o = cycle_q;

    p_cfa_fast_no_iordy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfa_q && pio_q > 3'd4) |-> !iordy_en_o);

endmodule

// File: rtl/cfide_win_decode.sv
`timescale 1ns/1ps
// Decodes the host address into a card window and a register index.
// Assumes each window spans eight registers at its base.
module cfide_win_decode
    import cfide_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr_i,
    output win_e              win_o,
    output logic [REG_W-1:0]  idx_o
);

    localparam int MID_W = ADDR_W - 3 - REG_W;

    logic [2:0]       mode;
    logic [MID_W-1:0] mid;

    // Picks the window from the mode bits; gaps inside the window miss.
    always_comb begin
        mode  = addr_i[ADDR_W-1 -: 3];
        mid   = addr_i[ADDR_W-4 : REG_W];
        idx_o = addr_i[REG_W-1:0];
        win_o = WIN_NONE;
        if (mid == '0) begin
            if (mode == 3'b110)      win_o = WIN_TASK;
            else if (mode == 3'b111) win_o = WIN_ALT;
        end
    end

endmodule

// File: rtl/cfide_cycle_seq.sv
`timescale 1ns/1ps
// Runs one timed PIO cycle per accepted request and the post-read float gap.
// Assumes pulse >= 1 and cycle >= setup + pulse for every decoded access.
module cfide_cycle_seq
    import cfide_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic              wide_i,
    input  win_e              win_i,
    input  logic [REG_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  setup_i,
    input  logic [CNT_W-1:0]  pulse_i,
    input  logic [CNT_W-1:0]  cycle_i,
    input  logic [CNT_W-1:0]  float_i,
    input  logic              iordy_en_i,
    input  logic              iordy_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              ack_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cs0_n_o,
    output logic              cs1_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [REG_W-1:0]  addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic [1:0]        doe_o
);

    localparam int SW = CNT_W + 1;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  t_q, fcnt_q;
    logic [CNT_W-1:0]  setup_q, pulse_q, cycle_q, float_q;
    logic              ien_q, we_q, wide_q;
    win_e              win_q;
    logic [REG_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              ack_q, done_q, err_q;

    logic [SW-1:0] t_x, pend_x, end_x;
    logic active, in_pulse, at_pend, stall, last, accept;

    // Locates the current clock inside the programmed cycle.
    always_comb begin
        t_x      = {1'b0, t_q};
        pend_x   = {1'b0, setup_q} + {1'b0, pulse_q} - SW'(1);
        end_x    = {1'b0, cycle_q} - SW'(1);
        active   = (state_q == ST_ACTIVE);
        in_pulse = active && (t_q >= setup_q) && (t_x <= pend_x);
        at_pend  = active && (t_x == pend_x);
        stall    = at_pend && ien_q && !iordy_i;
        last     = active && (t_x == end_x) && !stall;
        accept   = (state_q == ST_IDLE) && req_i;
    end

    // Steps the cycle state, snapshots timing, captures read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            fcnt_q  <= '0;
            setup_q <= '0;
            pulse_q <= '0;
            cycle_q <= '0;
            float_q <= '0;
            ien_q   <= 1'b0;
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
            win_q   <= WIN_NONE;
            idx_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ack_q  <= accept;
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        setup_q <= setup_i;
                        pulse_q <= pulse_i;
                        cycle_q <= cycle_i;
                        float_q <= float_i;
                        ien_q   <= iordy_en_i;
                        we_q    <= we_i;
                        wide_q  <= wide_i;
                        win_q   <= win_i;
                        idx_q   <= idx_i;
                        wdata_q <= wdata_i;
                        t_q     <= '0;
                        if (win_i != WIN_NONE) begin
                            state_q <= ST_ACTIVE;
                        end else begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (at_pend && !stall && !we_q)
                        rdata_q <= wide_q ? din_i : {8'h00, din_i[7:0]};
                    if (last) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                        if (!we_q && (float_i != '0 || float_q != '0) && float_q != '0) begin
                            state_q <= ST_FLOAT;
                            fcnt_q  <= float_q;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (!stall) begin
                        t_q <= t_q + CNT_W'(1);
                    end
                end
                ST_FLOAT: begin
                    if (fcnt_q <= CNT_W'(1)) state_q <= ST_IDLE;
                    else                     fcnt_q  <= fcnt_q - CNT_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drives the card pins from the registered cycle state.
    always_comb begin
        cs0_n_o = !(active && win_q == WIN_TASK);
        cs1_n_o = !(active && win_q == WIN_ALT);
        rd_n_o  = !(in_pulse && !we_q);
        wr_n_o  = !(in_pulse && we_q);
        addr_o  = idx_q;
        dout_o  = wide_q ? wdata_q : {8'h00, wdata_q[7:0]};
        doe_o   = (active && we_q) ? {wide_q, 1'b1} : 2'b00;
    end

    assign ack_o   = ack_q;
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign rdata_o = rdata_q;

    p_timing_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_i != WIN_NONE) |->
            (pulse_i != '0 && {1'b0, cycle_i} >= {1'b0, setup_i} + {1'b0, pulse_i}));

    p_iordy_holds_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_pend && ien_q && !iordy_i) |=> (!rd_n_o || !wr_n_o));

    p_float_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && !we_q && float_q != '0) |-> (cs0_n_o && cs1_n_o && !accept));

endmodule

// File: rtl/cfide_pio_engine.sv
`timescale 1ns/1ps
// Top level: CompactFlash True IDE PIO cycle engine.
// Assumes a synchronous card interface and a host that holds req until ack.
module cfide_pio_engine
    import cfide_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 100_000_000,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic              host_wide_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [15:0]       host_wdata_i,
    output logic              host_ack_o,
    output logic              host_done_o,
    output logic              host_err_o,
    output logic [15:0]       host_rdata_o,
    input  logic              cfg_wr_i,
    input  logic [CNT_W-1:0]  cfg_setup_i,
    input  logic [CNT_W-1:0]  cfg_pulse_i,
    input  logic [CNT_W-1:0]  cfg_cycle_i,
    input  logic [2:0]        cfg_pio_i,
    input  logic              cfg_dev_iordy_i,
    input  logic              cfg_is_cfa_i,
    output logic              ide_cs0_n_o,
    output logic              ide_cs1_n_o,
    output logic              ide_rd_n_o,
    output logic              ide_wr_n_o,
    output logic [2:0]        ide_addr_o,
    output logic [15:0]       ide_dout_o,
    output logic [1:0]        ide_doe_o,
    input  logic [15:0]       ide_din_i,
    input  logic              ide_iordy_i
);

    logic [CNT_W-1:0] t_setup, t_pulse, t_cycle, t_float;
    logic             t_ien;
    win_e             win;
    logic [REG_W-1:0] idx;

    cfide_timing_regs #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i),
        .setup_i(cfg_setup_i), .pulse_i(cfg_pulse_i), .cycle_i(cfg_cycle_i),
        .pio_i(cfg_pio_i), .dev_iordy_i(cfg_dev_iordy_i), .is_cfa_i(cfg_is_cfa_i),
        .setup_o(t_setup), .pulse_o(t_pulse), .cycle_o(t_cycle),
        .float_o(t_float), .iordy_en_o(t_ien)
    );

    cfide_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i(host_addr_i), .win_o(win), .idx_o(idx)
    );

    cfide_cycle_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_i(host_req_i), .we_i(host_we_i),
        .wide_i(host_wide_i), .win_i(win), .idx_i(idx), .wdata_i(host_wdata_i),
        .setup_i(t_setup), .pulse_i(t_pulse), .cycle_i(t_cycle), .float_i(t_float),
        .iordy_en_i(t_ien), .iordy_i(ide_iordy_i), .din_i(ide_din_i),
        .ack_o(host_ack_o), .done_o(host_done_o), .err_o(host_err_o),
        .rdata_o(host_rdata_o), .cs0_n_o(ide_cs0_n_o), .cs1_n_o(ide_cs1_n_o),
        .rd_n_o(ide_rd_n_o), .wr_n_o(ide_wr_n_o), .addr_o(ide_addr_o),
        .dout_o(ide_dout_o), .doe_o(ide_doe_o)
    );

    p_one_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_cs0_n_o && !ide_cs1_n_o));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_rd_n_o && !ide_wr_n_o));

    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_rd_n_o || !ide_wr_n_o) |-> (!ide_cs0_n_o || !ide_cs1_n_o));

    p_ack_first_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ide_cs0_n_o || !ide_cs1_n_o) && (!ide_cs0_n_o || !ide_cs1_n_o)) |-> !host_ack_o);

    p_done_after_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_done_o && !host_err_o) |-> (ide_cs0_n_o && ide_cs1_n_o));

    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_wr_n_o && $past(!ide_wr_n_o)) |-> $stable(ide_dout_o));

endmodule

// File: tb/cfide_pio_engine_bench.sv
`timescale 1ns/1ps
module cfide_pio_engine_bench;

    localparam longint unsigned HZ = 200_000_000;
    localparam int MHZ = 200;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0, wide = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic ack, done, err;
    logic [15:0] rdata;
    logic cfg_wr = 1'b0;
    logic [7:0] c_setup = '0, c_pulse = '0, c_cycle = '0;
    logic [2:0] c_pio = '0;
    logic c_dev = 1'b0, c_cfa = 1'b0;
    logic cs0_n, cs1_n, rd_n, wr_n;
    logic [2:0] ide_addr;
    logic [15:0] dout, din;
    logic [1:0] doe;
    logic iordy = 1'b1;

    cfide_pio_engine #(.CLK_HZ(HZ), .CNT_W(8), .ADDR_W(24)) u_cfide_pio_engine (
        .clk(clk), .rst_n(rst_n), .host_req_i(req), .host_we_i(we), .host_wide_i(wide),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_ack_o(ack), .host_done_o(done),
        .host_err_o(err), .host_rdata_o(rdata), .cfg_wr_i(cfg_wr), .cfg_setup_i(c_setup),
        .cfg_pulse_i(c_pulse), .cfg_cycle_i(c_cycle), .cfg_pio_i(c_pio),
        .cfg_dev_iordy_i(c_dev), .cfg_is_cfa_i(c_cfa), .ide_cs0_n_o(cs0_n),
        .ide_cs1_n_o(cs1_n), .ide_rd_n_o(rd_n), .ide_wr_n_o(wr_n), .ide_addr_o(ide_addr),
        .ide_dout_o(dout), .ide_doe_o(doe), .ide_din_i(din), .ide_iordy_i(iordy)
    );

    typedef struct {
        bit rd; bit alt; bit err;
        int cs_len; int stb_start; int stb_len;
        logic [15:0] rdata; logic [1:0] lanes; logic [15:0] dout;
        logic [2:0] addr; int gap;
    } item_t;

    item_t sb[$];
    int checks = 0, failures = 0, acks = 0, reqs = 0;
    bit finished = 1'b0;

    // Bench model of the timing registers (R1: PIO 0 after reset).
    int e_setup = (70 * MHZ + 999) / 1000;
    int e_pulse = (290 * MHZ + 999) / 1000;
    int e_cycle = (600 * MHZ + 999) / 1000;
    int e_float = (30 * MHZ + 999) / 1000;
    bit e_ien = 1'b0;
    int iordy_w = 0;

    function automatic logic [15:0] card_word(logic [2:0] a);
        return {5'b10110, a, 5'b01001, a};
    endfunction

    assign din = card_word(ide_addr);

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Card IORDY model: low for the first iordy_w strobe clocks.
    int k = 0;
    always @(negedge clk) begin
        if (!rd_n || !wr_n) begin
            iordy = (k >= iordy_w);
            k++;
        end else begin
            k = 0;
            iordy = 1'b1;
        end
    end

    // Monitor: measures each bus cycle and compares at done.
    bit in_cyc = 0, seen = 0, m_rd = 0, m_wr = 0, m_alt = 0;
    int m_len = 0, m_start = -1, m_slen = 0, m_gap = 0, idle_cnt = 1000;
    logic [2:0] m_addr = '0;
    logic [1:0] m_doe = '0;
    logic [15:0] m_dout = '0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!cs0_n || !cs1_n) begin
                if (!in_cyc) begin
                    in_cyc = 1; seen = 1; m_len = 0; m_start = -1; m_slen = 0;
                    m_alt = !cs1_n; m_gap = idle_cnt; m_rd = 0; m_wr = 0; m_addr = ide_addr;
                end
                if (!rd_n || !wr_n) begin
                    if (m_start < 0) m_start = m_len;
                    m_slen++;
                    if (!rd_n) m_rd = 1;
                    if (!wr_n) begin m_wr = 1; m_doe = doe; m_dout = dout; end
                end
                m_len++;
                idle_cnt = 0;
            end else begin
                in_cyc = 0;
                idle_cnt++;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(0, "R6 done without a pending request", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(err == it.err, "R2 err flag", err, it.err);
                    if (it.err) begin
                        check(!seen, "R2 no bus cycle on miss", seen, 0);
                        check(rdata == 16'h0, "R2 rdata on miss", rdata, 0);
                    end else begin
                        check(seen, "R6 one bus cycle per done", seen, 1);
                        check(m_len == it.cs_len, "R3 R8 chip select length", m_len, it.cs_len);
                        check(m_start == it.stb_start, "R4 strobe setup", m_start, it.stb_start);
                        check(m_slen == it.stb_len, "R4 R8 strobe length", m_slen, it.stb_len);
                        check(m_rd == it.rd && m_wr == !it.rd, "R4 strobe kind", {m_rd, m_wr}, {it.rd, !it.rd});
                        check(m_alt == it.alt, "R2 window", m_alt, it.alt);
                        check(m_addr == it.addr, "R12 card address", m_addr, it.addr);
                        if (it.rd) check(rdata == it.rdata, "R5 read data", rdata, it.rdata);
                        else begin
                            check(m_doe == it.lanes, "R5 lane enables", m_doe, it.lanes);
                            check(m_dout == it.dout, "R5 write data", m_dout, it.dout);
                        end
                        if (it.gap >= 0) check(m_gap == it.gap, "R7 turnaround gap", m_gap, it.gap);
                    end
                end
                seen = 0;
            end
        end
    end

    // mode 0: wait for done; 1: keep req for a chained request; 2: drop req, no wait.
    task automatic access(bit w, bit wd16, logic [23:0] a, logic [15:0] d, int gap, int mode);
        item_t it;
        logic [15:0] cw;
        cw = card_word(a[2:0]);
        it.rd = !w;
        it.alt = (a[23:21] == 3'b111);
        it.err = !((a[23:22] == 2'b11) && (a[20:3] == 0));
        it.stb_len = (e_ien && iordy_w + 1 > e_pulse) ? iordy_w + 1 : e_pulse;
        it.cs_len = e_cycle + it.stb_len - e_pulse;
        it.stb_start = e_setup;
        it.rdata = it.err ? 16'h0 : (wd16 ? cw : {8'h00, cw[7:0]});
        it.lanes = {wd16, 1'b1};
        it.dout = wd16 ? d : {8'h00, d[7:0]};
        it.addr = a[2:0];
        it.gap = gap;
        sb.push_back(it);
        we = w; wide = wd16; addr = a; wdata = d; req = 1'b1; reqs++;
        do @(negedge clk); while (!ack);
        acks++;
        if (mode != 1) req = 1'b0;
        if (mode == 0 && !done) begin
            do @(negedge clk); while (!done);
        end
    endtask

    task automatic cfg(int s, int p, int c, int pio, bit dev, bit cfa);
        c_setup = 8'(s); c_pulse = 8'(p); c_cycle = 8'(c);
        c_pio = 3'(pio); c_dev = dev; c_cfa = cfa; cfg_wr = 1'b1;
        e_setup = s; e_pulse = p; e_cycle = c;
        e_ien = (pio > 2 || dev) && !(cfa && pio > 4);                      // R9
        e_float = (pio >= 5) ? (20 * MHZ + 999) / 1000 : (30 * MHZ + 999) / 1000; // R10
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle bus and quiet host outputs in reset
        check(cs0_n && cs1_n && rd_n && wr_n && doe == 2'b00, "R1 bus idle in reset",
              {cs0_n, cs1_n, rd_n, wr_n, doe}, 6'b111100);
        check(!ack && !done, "R1 ack/done low in reset", {ack, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs0_n && cs1_n && !ack && !done, "R1 idle after reset", {cs0_n, cs1_n, ack, done}, 4'b1100);

        // R1 R3 R4 R5: PIO 0 defaults, byte and word, both directions
        access(0, 0, 24'hC00001, 16'h0, -1, 0);
        access(1, 1, 24'hC00000, 16'hBEEF, -1, 0);
        access(1, 0, 24'hC00007, 16'h12E7, -1, 0);
        access(0, 1, 24'hC00000, 16'h0, -1, 0);
        // R2: alternate window and misses
        access(0, 0, 24'hE00006, 16'h0, -1, 0);
        access(0, 0, 24'h400002, 16'h0, -1, 0);
        access(1, 0, 24'hC00010, 16'h0055, -1, 0);

        // R7: chained traffic; read->x gap float+1, write->x gap 1
        cfg(2, 3, 8, 1, 0, 0);
        access(0, 0, 24'hC00002, 16'h0, -1, 1);
        access(0, 1, 24'hC00000, 16'h0, e_float + 1, 1);
        access(1, 0, 24'hC00003, 16'h00A1, e_float + 1, 1);
        access(0, 0, 24'hC00004, 16'h0, 1, 0);

        // R3 R4: cycle equal to setup+pulse, and zero setup
        cfg(1, 2, 3, 1, 0, 0);
        access(1, 1, 24'hC00000, 16'h5AC3, -1, 1);
        access(0, 0, 24'hC00005, 16'h0, 1, 0);
        cfg(0, 2, 4, 1, 0, 0);
        access(0, 0, 24'hE00006, 16'h0, -1, 0);

        // R8 R9: IORDY stretch in PIO 3
        cfg(2, 3, 8, 3, 0, 0);
        iordy_w = 6; access(0, 0, 24'hC00001, 16'h0, -1, 0);
        iordy_w = 2; access(0, 0, 24'hC00002, 16'h0, -1, 0);
        iordy_w = 3; access(0, 0, 24'hC00003, 16'h0, -1, 0);
        iordy_w = 5; access(1, 1, 24'hC00000, 16'h1357, -1, 0);
        // R9: policy corners, IORDY held low for 6 strobe clocks each time
        iordy_w = 6;
        cfg(2, 3, 8, 1, 0, 0); access(0, 0, 24'hC00001, 16'h0, -1, 0);
        cfg(2, 3, 8, 1, 1, 0); access(0, 0, 24'hC00001, 16'h0, -1, 0);
        cfg(2, 3, 8, 4, 0, 1); access(0, 0, 24'hC00001, 16'h0, -1, 0);
        cfg(2, 3, 8, 5, 0, 0); access(0, 0, 24'hC00001, 16'h0, -1, 0);
        cfg(2, 3, 8, 5, 0, 1); access(0, 0, 24'hC00001, 16'h0, -1, 0);
        // R10: mode 5 float is the 20 ns count
        iordy_w = 0;
        access(0, 0, 24'hC00006, 16'h0, -1, 1);
        access(0, 0, 24'hC00005, 16'h0, e_float + 1, 0);
        check(e_float == 4, "R10 bench float for mode 5", e_float, 4);

        // R11: configuration written mid-cycle applies to the next access only
        cfg(2, 3, 8, 1, 0, 0);
        access(0, 0, 24'hC00001, 16'h0, -1, 2);
        cfg(4, 5, 12, 1, 0, 0);
        if (!done) begin
            do @(negedge clk); while (!done);
        end
        access(0, 0, 24'hC00002, 16'h0, -1, 0);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R6 every request completed", sb.size(), 0);
        check(acks == reqs, "R6 one ack per request", acks, reqs);
        finish_run();
    end

endmodule